// File: doc/BRIEF.md
# Segment-Register Address Expander with Segment-Tagged TLB

This block widens a 32-bit effective address into a longer system virtual address and then translates that virtual address to a real page through a small translation buffer. The top four bits of the effective address choose one of sixteen segment registers. The identifier held in that register is placed in front of the remaining 28 offset bits, which gives a 40-bit virtual address with the default 12-bit identifier. Software can load any segment register in any cycle, in the same way it would update an ordinary general register.

The buffer is two-way set associative with 32 sets and 4 KiB pages. Its tags are built from the segment identifier, not from a process or address-space number. Two programs that load the same identifier into their segment registers therefore hit the same buffer entry for a shared segment. When a lookup misses, the block reports the full virtual page number for a walker outside the block. That walker later installs the translation through a fill port. The identifier width is a parameter, so a 24-bit identifier gives a 52-bit virtual address.

Top module: `segxl_top`

## Requirements
- R1: After reset every buffer entry is invalid, every segment register holds zero, and `xl_done`, `xl_hit` and `xl_miss` are low, so the first lookup of any address misses.
- R2: `xl_ea[31:28]` selects the segment register. The virtual page number is the selected identifier followed by `xl_ea[27:12]`. On a miss, `xl_miss_vpn` carries this number.
- R3: A segment-register write accepted on one clock edge is used by a lookup issued in the very next cycle.
- R4: A lookup requested in cycle N produces its result one cycle later. `xl_done` is high for exactly that cycle, with exactly one of `xl_hit` and `xl_miss` high. All three are low in cycles that follow no request.
- R5: On a hit, `xl_pa` is the stored real page number (bits 31:12) joined with `xl_ea[11:0]`.
- R6: Two segment registers that hold the same identifier reach the same buffer entry, so a page filled once hits through either register.
- R7: The same 28-bit offset under a different identifier misses.
- R8: The set index is the low 5 bits of the virtual page number. A set holds two different pages at once.
- R9: A fill into a full set replaces the least recently used way. Both a hit and a fill make their way the most recently used one.
- R10: A fill for a page already present rewrites the way that holds it, so a later hit returns the new real page and the other way is kept.
- R11: A lookup issued in the same cycle as a fill of the same page sees the contents from before the fill and misses. The next lookup hits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| sr_we | input | 1 | Segment-register write strobe |
| sr_idx | input | 4 | Segment register to write |
| sr_sid | input | SID_W (12) | Identifier to store |
| xl_req | input | 1 | Lookup request |
| xl_ea | input | 32 | Effective address to translate |
| xl_done | output | 1 | Result valid, one cycle after the request |
| xl_hit | output | 1 | Lookup hit |
| xl_miss | output | 1 | Lookup missed |
| xl_pa | output | 32 | Real address on a hit, zero otherwise |
| xl_miss_vpn | output | SID_W+16 (28) | Virtual page number on a miss, zero otherwise |
| fill_valid | input | 1 | Install a translation |
| fill_vpn | input | SID_W+16 (28) | Virtual page number to install |
| fill_rpn | input | 20 | Real page number to install |

## Verification
Lookups use addresses that differ in only one part at a time: the segment selector, the identifier held in the selected register, or the page offset. This separates an expander that joins the wrong bits from a buffer that compares the wrong tag. Shared-identifier lookups through two registers show that tags carry no process context. Reloading a register before a repeat lookup shows the one-cycle visibility of writes. Filling a set with three pages while touching one of them in between shows whether the victim follows recency, and refilling a resident page shows whether a duplicate entry would be created.

// File: rtl/segxl_pkg.sv
// Package: shared constants and types of the segment-register address expander.
// Assumes: the buffer associativity is fixed at two ways (one LRU bit per set).
package segxl_pkg;
    localparam int NUM_WAYS = 2;

    typedef enum logic {
        WAY_A = 1'b0,
        WAY_B = 1'b1
    } way_e;
endpackage

// File: rtl/segxl_segregs.sv
// Module: bank of segment registers holding segment identifiers.
// What it does: one synchronous write port and one combinational read port.
// Assumes: a write lands on the clock edge, so a read in the following cycle
// returns the new value; reset clears every register to zero.
module segxl_segregs #(
    parameter int SEG_COUNT = 16,
    parameter int SID_W     = 12,
    localparam int SEL_W    = $clog2(SEG_COUNT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [SID_W-1:0] wr_sid,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [SID_W-1:0] rd_sid
);

    logic [SID_W-1:0] regs_q [SEG_COUNT];

    // Register bank update: clear on reset, else load the addressed entry.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SEG_COUNT; i++) begin
                regs_q[i] <= '0;
            end
        end else if (wr_en) begin
            regs_q[wr_sel] <= wr_sid;
        end
    end

    // Read port: identifier of the selected register.
    always_comb begin
        rd_sid = regs_q[rd_sel];
    end

    // A write must be readable one cycle later.
    p_sr_write_visible_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (regs_q[$past(wr_sel)] == $past(wr_sid)));

endmodule

// File: rtl/segxl_tlb_way.sv
// Module: one way of the segment-tagged translation buffer.
// What it does: holds valid, tag and real page per set; offers one lookup
// compare port, one fill compare port and one write port.
// Assumes: reads are combinational and a write takes effect at the clock edge.
module segxl_tlb_way #(
    parameter int SETS  = 32,
    parameter int TAG_W = 23,
    parameter int RPN_W = 20,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [IDX_W-1:0] lk_idx,
    input  logic [TAG_W-1:0] lk_tag,
    output logic             lk_hit,
    output logic [RPN_W-1:0] lk_rpn,
    input  logic [IDX_W-1:0] cmp_idx,
    input  logic [TAG_W-1:0] cmp_tag,
    output logic             cmp_hit,
    input  logic             wr_en,
    input  logic [IDX_W-1:0] wr_idx,
    input  logic [TAG_W-1:0] wr_tag,
    input  logic [RPN_W-1:0] wr_rpn
);

    logic             valid_q [SETS];
    logic [TAG_W-1:0] tag_q   [SETS];
    logic [RPN_W-1:0] rpn_q   [SETS];

    // Valid bits: cleared on reset, set by a write.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                valid_q[i] <= 1'b0;
            end
        end else if (wr_en) begin
            valid_q[wr_idx] <= 1'b1;
        end
    end

    // Tag and page storage: written with the entry, no reset needed.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            tag_q[wr_idx] <= wr_tag;
            rpn_q[wr_idx] <= wr_rpn;
        end
    end

    // Lookup compare and fill compare.
    always_comb begin
        lk_hit  = valid_q[lk_idx] && (tag_q[lk_idx] == lk_tag);
        lk_rpn  = rpn_q[lk_idx];
        cmp_hit = valid_q[cmp_idx] && (tag_q[cmp_idx] == cmp_tag);
    end

    // A written entry must read back as present.
    p_write_lands_r10: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (valid_q[$past(wr_idx)] && tag_q[$past(wr_idx)] == $past(wr_tag)));

endmodule

// File: rtl/segxl_lru.sv
// Module: per-set least-recently-used tracking for the two-way buffer.
// What it does: one bit per set names the way to evict next; a lookup hit
// and a fill each make their way the most recent.
// Assumes: when a touch and a fill hit the same set in one cycle, the fill wins.
module segxl_lru #(
    parameter int SETS = 32,
    localparam int IDX_W = $clog2(SETS)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              touch_en,
    input  logic [IDX_W-1:0]  touch_idx,
    input  segxl_pkg::way_e   touch_way,
    input  logic              fill_en,
    input  logic [IDX_W-1:0]  fill_idx,
    input  segxl_pkg::way_e   fill_way,
    input  logic [IDX_W-1:0]  q_idx,
    output segxl_pkg::way_e   q_victim
);

    logic lru_q [SETS];

    // Recency update: fill is applied after touch so it takes priority.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < SETS; i++) begin
                lru_q[i] <= 1'b0;
            end
        end else begin
            if (touch_en) begin
                lru_q[touch_idx] <= ~touch_way;
            end
            if (fill_en) begin
                lru_q[fill_idx] <= ~fill_way;
            end
        end
    end

    // Victim for the queried set.
    always_comb begin
        q_victim = segxl_pkg::way_e'(lru_q[q_idx]);
    end

    // After a fill, the filled way must not be the next victim.
    p_fill_not_victim_r9: assert property (@(posedge clk) disable iff (!rst_n)
        fill_en |=> (lru_q[$past(fill_idx)] != $past(fill_way)));

endmodule

// File: rtl/segxl_top.sv
// Module: segment-register address expander with a segment-tagged TLB.
// What it does: picks a segment register with the top address bits, joins its
// identifier to the offset, looks the virtual page up in a two-way buffer and
// registers hit/real address or miss/virtual page one cycle later.
// Assumes: fills come from an outside walker; a same-cycle lookup sees the
// contents from before the fill.
module segxl_top #(
    parameter int EA_W      = 32,
    parameter int SEG_COUNT = 16,
    parameter int SID_W     = 12,
    parameter int PAGE_W    = 12,
    parameter int SETS      = 32,
    parameter int RPN_W     = 20,
    localparam int SEL_W    = $clog2(SEG_COUNT),
    localparam int OFF_W    = EA_W - SEL_W,
    localparam int VA_W     = SID_W + OFF_W,
    localparam int VPN_W    = VA_W - PAGE_W,
    localparam int IDX_W    = $clog2(SETS),
    localparam int TAG_W    = VPN_W - IDX_W,
    localparam int PA_W     = RPN_W + PAGE_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             sr_we,
    input  logic [SEL_W-1:0] sr_idx,
    input  logic [SID_W-1:0] sr_sid,
    input  logic             xl_req,
    input  logic [EA_W-1:0]  xl_ea,
    output logic             xl_done,
    output logic             xl_hit,
    output logic             xl_miss,
    output logic [PA_W-1:0]  xl_pa,
    output logic [VPN_W-1:0] xl_miss_vpn,
    input  logic             fill_valid,
    input  logic [VPN_W-1:0] fill_vpn,
    input  logic [RPN_W-1:0] fill_rpn
);
    import segxl_pkg::*;

    logic [SID_W-1:0] cur_sid;
    logic [VA_W-1:0]  lk_va;
    logic [VPN_W-1:0] lk_vpn;
    logic [IDX_W-1:0] lk_idx;
    logic [TAG_W-1:0] lk_tag;
    logic [IDX_W-1:0] fl_idx;
    logic [TAG_W-1:0] fl_tag;

    logic [NUM_WAYS-1:0] way_hit;
    logic [NUM_WAYS-1:0] way_cmp;
    logic [RPN_W-1:0]    way_rpn [NUM_WAYS];
    logic                any_hit;
    way_e                hit_way;
    way_e                victim;
    way_e                fill_way;
    logic [RPN_W-1:0]    hit_rpn;

    segxl_segregs #(
        .SEG_COUNT (SEG_COUNT),
        .SID_W     (SID_W)
    ) u_segregs (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_en  (sr_we),
        .wr_sel (sr_idx),
        .wr_sid (sr_sid),
        .rd_sel (xl_ea[EA_W-1 -: SEL_W]),
        .rd_sid (cur_sid)
    );

    // Address expansion: identifier in front of the offset; split page number.
    always_comb begin
        lk_va  = {cur_sid, xl_ea[OFF_W-1:0]};
        lk_vpn = lk_va[VA_W-1:PAGE_W];
        lk_idx = lk_vpn[IDX_W-1:0];
        lk_tag = lk_vpn[VPN_W-1:IDX_W];
        fl_idx = fill_vpn[IDX_W-1:0];
        fl_tag = fill_vpn[VPN_W-1:IDX_W];
    end

    for (genvar w = 0; w < NUM_WAYS; w++) begin : g_way
        segxl_tlb_way #(
            .SETS  (SETS),
            .TAG_W (TAG_W),
            .RPN_W (RPN_W)
        ) u_way (
            .clk     (clk),
            .rst_n   (rst_n),
            .lk_idx  (lk_idx),
            .lk_tag  (lk_tag),
            .lk_hit  (way_hit[w]),
            .lk_rpn  (way_rpn[w]),
            .cmp_idx (fl_idx),
            .cmp_tag (fl_tag),
            .cmp_hit (way_cmp[w]),
            .wr_en   (fill_valid && (fill_way == way_e'(w))),
            .wr_idx  (fl_idx),
            .wr_tag  (fl_tag),
            .wr_rpn  (fill_rpn)
        );
    end

    segxl_lru #(
        .SETS (SETS)
    ) u_lru (
        .clk       (clk),
        .rst_n     (rst_n),
        .touch_en  (xl_req && any_hit),
        .touch_idx (lk_idx),
        .touch_way (hit_way),
        .fill_en   (fill_valid),
        .fill_idx  (fl_idx),
        .fill_way  (fill_way),
        .q_idx     (fl_idx),
        .q_victim  (victim)
    );

    // Hit resolution and fill way choice: a resident page is rewritten in place.
    always_comb begin
        any_hit = |way_hit;
        hit_way = way_hit[1] ? WAY_B : WAY_A;
        hit_rpn = way_rpn[hit_way];
        if (way_cmp[1]) begin
            fill_way = WAY_B;
        end else if (way_cmp[0]) begin
            fill_way = WAY_A;
        end else begin
            fill_way = victim;
        end
    end

    // Result register: one-cycle lookup latency.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            xl_done     <= 1'b0;
            xl_hit      <= 1'b0;
            xl_miss     <= 1'b0;
            xl_pa       <= '0;
            xl_miss_vpn <= '0;
        end else begin
            xl_done     <= xl_req;
            xl_hit      <= xl_req && any_hit;
            xl_miss     <= xl_req && !any_hit;
            xl_pa       <= (xl_req && any_hit) ? {hit_rpn, xl_ea[PAGE_W-1:0]} : '0;
            xl_miss_vpn <= (xl_req && !any_hit) ? lk_vpn : '0;
        end
    end

    p_result_follows_req_r4: assert property (@(posedge clk) disable iff (!rst_n)
        xl_req |=> (xl_done && (xl_hit != xl_miss)));

    p_idle_quiet_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !xl_done |-> (!xl_hit && !xl_miss));

    p_no_dup_way_r10: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(way_hit));

    p_miss_offset_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && !any_hit) |=> (xl_miss_vpn[OFF_W-PAGE_W-1:0] == $past(xl_ea[OFF_W-1:PAGE_W])));

    p_hit_offset_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (xl_req && any_hit) |=> (xl_pa[PAGE_W-1:0] == $past(xl_ea[PAGE_W-1:0])));

endmodule

// File: tb/segxl_top_bench.sv
// Directed bench for the segment-register address expander.
module segxl_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        sr_we = 1'b0;
    logic [3:0]  sr_idx = '0;
    logic [11:0] sr_sid = '0;
    logic        xl_req = 1'b0;
    logic [31:0] xl_ea = '0;
    logic        xl_done, xl_hit, xl_miss;
    logic [31:0] xl_pa;
    logic [27:0] xl_miss_vpn;
    logic        fill_valid = 1'b0;
    logic [27:0] fill_vpn = '0;
    logic [19:0] fill_rpn = '0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    segxl_top u_segxl_top (
        .clk         (clk),
        .rst_n       (rst_n),
        .sr_we       (sr_we),
        .sr_idx      (sr_idx),
        .sr_sid      (sr_sid),
        .xl_req      (xl_req),
        .xl_ea       (xl_ea),
        .xl_done     (xl_done),
        .xl_hit      (xl_hit),
        .xl_miss     (xl_miss),
        .xl_pa       (xl_pa),
        .xl_miss_vpn (xl_miss_vpn),
        .fill_valid  (fill_valid),
        .fill_vpn    (fill_vpn),
        .fill_rpn    (fill_rpn)
    );

    task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic [27:0] vpn_of(input logic [11:0] sid, input logic [31:0] ea);
        return {sid, ea[27:12]};
    endfunction

    // Write a segment register over one cycle; inputs change at the falling edge.
    task automatic seg_write(input logic [3:0] idx, input logic [11:0] sid);
        sr_we = 1'b1; sr_idx = idx; sr_sid = sid;
        @(negedge clk);
        sr_we = 1'b0;
    endtask

    task automatic fill(input logic [27:0] vpn, input logic [19:0] rpn);
        fill_valid = 1'b1; fill_vpn = vpn; fill_rpn = rpn;
        @(negedge clk);
        fill_valid = 1'b0;
    endtask

    // Issue one lookup and check a hit with the expected real address.
    task automatic expect_hit(input string req, input logic [31:0] ea, input logic [19:0] rpn);
        xl_req = 1'b1; xl_ea = ea;
        @(negedge clk);
        xl_req = 1'b0;
        chk({req, " done"}, xl_done, 1'b1);
        chk({req, " hit"}, {xl_hit, xl_miss}, 2'b10);
        chk({req, " pa"}, xl_pa, {rpn, ea[11:0]});
    endtask

    // Issue one lookup and check a miss with the expected page number.
    task automatic expect_miss(input string req, input logic [31:0] ea, input logic [27:0] vpn);
        xl_req = 1'b1; xl_ea = ea;
        @(negedge clk);
        xl_req = 1'b0;
        chk({req, " done"}, xl_done, 1'b1);
        chk({req, " miss"}, {xl_hit, xl_miss}, 2'b01);
        chk({req, " vpn"}, xl_miss_vpn, vpn);
    endtask

    task automatic t_reset();
        chk("R1 done low", xl_done, 1'b0);
        chk("R1 hit/miss low", {xl_hit, xl_miss}, 2'b00);
        expect_miss("R1 empty", 32'hF00D_5123, vpn_of(12'h000, 32'hF00D_5123));
        @(negedge clk);
        chk("R4 idle quiet", {xl_done, xl_hit, xl_miss}, 3'b000);
    endtask

    task automatic t_expand_and_hit();
        seg_write(4'h3, 12'hABC);
        expect_miss("R3 R2 expand", 32'h3123_4567, 28'hABC1234);
        fill(28'hABC1234, 20'h55AA5);
        expect_hit("R5 hit", 32'h3123_4567, 20'h55AA5);
        expect_hit("R5 other offset", 32'h3123_4FFE, 20'h55AA5);
        expect_miss("R2 selector", 32'h4123_4567, vpn_of(12'h000, 32'h4123_4567));
    endtask

    task automatic t_shared();
        seg_write(4'h9, 12'hABC);
        expect_hit("R6 shared", 32'h9123_4890, 20'h55AA5);
        seg_write(4'h9, 12'h123);
        expect_miss("R7 other sid", 32'h9123_4890, 28'h1231234);
        seg_write(4'h9, 12'hABC);
        expect_hit("R3 reload back", 32'h9123_4890, 20'h55AA5);
    endtask

    task automatic t_sets_and_lru();
        // Pages 0x0040 under sid 1, 2, 4: index bits [4:0] are all zero.
        seg_write(4'h1, 12'h001);
        seg_write(4'h2, 12'h002);
        seg_write(4'h4, 12'h004);
        fill(vpn_of(12'h001, 32'h1004_0000), 20'h0A001);
        fill(vpn_of(12'h002, 32'h2004_0000), 20'h0B002);
        expect_hit("R8 way A", 32'h1004_0010, 20'h0A001);
        expect_hit("R8 way B", 32'h2004_0020, 20'h0B002);
        expect_hit("R9 touch A", 32'h1004_0030, 20'h0A001);
        fill(vpn_of(12'h004, 32'h4004_0000), 20'h0C004);
        expect_hit("R9 new C", 32'h4004_0040, 20'h0C004);
        expect_hit("R9 A kept", 32'h1004_0050, 20'h0A001);
        expect_miss("R9 B evicted", 32'h2004_0060, vpn_of(12'h002, 32'h2004_0060));
        fill(vpn_of(12'h001, 32'h1004_0000), 20'h0D111);
        expect_hit("R10 rewritten", 32'h1004_0070, 20'h0D111);
        expect_hit("R10 C kept", 32'h4004_0080, 20'h0C004);
        expect_hit("R8 other set", 32'h3123_4001, 20'h55AA5);
    endtask

    task automatic t_same_cycle_fill();
        seg_write(4'h5, 12'h0AA);
        xl_req = 1'b1; xl_ea = 32'h5007_7321;
        fill_valid = 1'b1; fill_vpn = vpn_of(12'h0AA, 32'h5007_7321); fill_rpn = 20'h77777;
        @(negedge clk);
        xl_req = 1'b0; fill_valid = 1'b0;
        chk("R11 same-cycle miss", {xl_done, xl_hit, xl_miss}, 3'b101);
        expect_hit("R11 next hit", 32'h5007_7321, 20'h77777);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_expand_and_hit();
        t_shared();
        t_sets_and_lru();
        t_same_cycle_fill();
        finished = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual running expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule